// File: doc/BRIEF.md
# Near Call and Return Sequencer

This block performs the control-flow half of near subroutine calls and returns for a 64-bit core. A command comes in as one cycle of `cmd_valid` while the block is idle. It carries the operation kind, the address of the next instruction, the current stack pointer and the operands. The block then runs the stack and operand memory accesses the operation needs over a simple synchronous memory port. Each access is held until `mem_ready` is sampled high. When the last access completes, the block presents the new instruction pointer and stack pointer and pulses `done`.

A call first computes its target. For a relative call this is the next-instruction address plus a sign-extended 32-bit displacement. For an indirect call it is a register value, or a qword read from memory. The call then pushes the next-instruction address one slot below the stack pointer. A return pops the target from the top of the stack. It can also discard an extra 16-bit byte count of stack. Every stack address is the stack-segment base plus a stack pointer.

Top module: `nearxfer_seq`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd` and `mem_wr` are 0, and `rip_out` and `rsp_out` are 0.
- R2: A relative call (`cmd_kind` = 0) ends with `rip_out` = `cmd_next_ip` + sign-extended `cmd_disp`, modulo 2^64.
- R3: Every call writes `cmd_next_ip` to address `ss_base` + `cmd_rsp` − 8 as its last access, and ends with `rsp_out` = `cmd_rsp` − 8 (modulo 2^64). The `done` pulse follows the cycle in which that write is accepted.
- R4: An indirect call (`cmd_kind` = 1) with `cmd_opnd_mem` = 0 makes no read and ends with `rip_out` = `cmd_opnd_reg`.
- R5: An indirect call with `cmd_opnd_mem` = 1 first reads the qword at `cmd_opnd_addr`, then makes the push, and ends with `rip_out` equal to the value read.
- R6: A plain return (`cmd_kind` = 2) reads the qword at `ss_base` + `cmd_rsp`, ends with `rip_out` equal to that value and `rsp_out` = `cmd_rsp` + 8 (modulo 2^64), and makes no write.
- R7: A return with release (`cmd_kind` = 3) behaves as R6, except that `rsp_out` = `cmd_rsp` + 8 + zero-extended `cmd_imm`.
- R8: At most one of `mem_rd` and `mem_wr` is high in any cycle. While a strobe is high and `mem_ready` is low, the strobe, `mem_addr` and `mem_wdata` hold.
- R9: `done` is a single-cycle pulse, one per accepted command. `rip_out` and `rsp_out` change only in the cycle in which `done` is high.
- R10: `busy` is high from the cycle after acceptance until `done`. A `cmd_valid` seen while busy is ignored, and no memory strobe is raised while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd_kind | input | 2 | 0 relative call, 1 indirect call, 2 return, 3 return with release |
| cmd_next_ip | input | 64 | Address of the next instruction |
| cmd_rsp | input | 64 | Stack pointer before the operation |
| cmd_disp | input | 32 | Signed displacement for a relative call |
| cmd_imm | input | 16 | Extra byte count released by kind 3 |
| cmd_opnd_mem | input | 1 | Indirect target source: 1 memory qword, 0 register |
| cmd_opnd_reg | input | 64 | Register target for an indirect call |
| cmd_opnd_addr | input | 64 | Address of the memory target qword |
| ss_base | input | 64 | Stack-segment base added to every stack address |
| busy | output | 1 | Command in progress |
| mem_addr | output | 64 | Memory access address |
| mem_wdata | output | 64 | Memory write data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | 64 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Current access completes this cycle |
| rip_out | output | 64 | Updated instruction pointer |
| rsp_out | output | 64 | Updated stack pointer |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bound checker watches the memory handshake on every cycle. It checks that strobes are exclusive and that the address and data hold while an access stalls. It also checks that `done` lasts one cycle, that results stay frozen between pulses, that the bus is quiet while idle, and that a fetch is followed by a push and a push by `done`. The arithmetic needs the bench's scenarios. These cover sign extension of the most negative displacement, wrap of the stack pointer through zero, the largest release count, the order and addresses of the accesses, and junk commands driven throughout each busy period.

// File: rtl/nearxfer_pkg.sv
package nearxfer_pkg;

    localparam int VA_W       = 64;
    localparam int DISP_W     = 32;
    localparam int IMM_W      = 16;
    localparam int SLOT_BYTES = 8;

    typedef enum logic [1:0] {
        K_CALL_REL = 2'd0,
        K_CALL_IND = 2'd1,
        K_RET      = 2'd2,
        K_RET_IMM  = 2'd3
    } xfer_kind_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_PUSH  = 2'd2,
        S_POP   = 2'd3
    } seq_state_e;

    typedef struct packed {
        xfer_kind_e            kind;
        logic                  opnd_mem;
        logic [VA_W-1:0]       next_ip;
        logic [VA_W-1:0]       rsp;
        logic [VA_W-1:0]       target;
        logic [VA_W-1:0]       opnd_addr;
        logic [IMM_W-1:0]      imm;
    } xfer_cmd_t;

    function automatic logic [VA_W-1:0] sext_disp(input logic [DISP_W-1:0] d);
        return {{(VA_W-DISP_W){d[DISP_W-1]}}, d};
    endfunction

    function automatic logic [VA_W-1:0] zext_imm(input logic [IMM_W-1:0] v);
        return {{(VA_W-IMM_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/nearxfer_target_sel.sv
module nearxfer_target_sel
    import nearxfer_pkg::*;
(
    input  xfer_kind_e         kind,
    input  logic [VA_W-1:0]    next_ip,
    input  logic [DISP_W-1:0]  disp,
    input  logic [VA_W-1:0]    opnd_reg,
    output logic [VA_W-1:0]    target
);
    always_comb begin
        unique case (kind)
            K_CALL_REL: target = next_ip + sext_disp(disp);
            K_CALL_IND: target = opnd_reg;
            default:    target = '0;
        endcase
    end
endmodule

// File: rtl/nearxfer_stack_agu.sv
module nearxfer_stack_agu
    import nearxfer_pkg::*;
#(
    parameter int AW    = VA_W,
    parameter int IW    = IMM_W,
    parameter int SLOT  = SLOT_BYTES
) (
    input  logic [AW-1:0]  ss_base,
    input  logic [AW-1:0]  rsp,
    input  logic [IW-1:0]  imm,
    input  logic           use_imm,
    output logic [AW-1:0]  push_addr,
    output logic [AW-1:0]  pop_addr,
    output logic [AW-1:0]  rsp_after_push,
    output logic [AW-1:0]  rsp_after_pop
);
    localparam logic [AW-1:0] SLOT_V = AW'(SLOT);

    logic [AW-1:0] release_bytes;

    always_comb begin
        release_bytes  = use_imm ? {{(AW-IW){1'b0}}, imm} : '0;
        rsp_after_push = rsp - SLOT_V;
        rsp_after_pop  = rsp + SLOT_V + release_bytes;
        push_addr      = ss_base + rsp_after_push;
        pop_addr       = ss_base + rsp;
    end
endmodule

// File: rtl/nearxfer_ctrl.sv
module nearxfer_ctrl
    import nearxfer_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  xfer_cmd_t          cmd_in,
    input  logic [VA_W-1:0]    push_addr,
    input  logic [VA_W-1:0]    pop_addr,
    input  logic [VA_W-1:0]    rsp_after_push,
    input  logic [VA_W-1:0]    rsp_after_pop,
    input  logic [VA_W-1:0]    mem_rdata,
    input  logic               mem_ready,
    output xfer_cmd_t          cmd_q,
    output logic [VA_W-1:0]    mem_addr,
    output logic [VA_W-1:0]    mem_wdata,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic [VA_W-1:0]    rip_q,
    output logic [VA_W-1:0]    rsp_q,
    output logic               done,
    output logic               busy
);
    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cmd_q <= '0;
            rip_q <= '0;
            rsp_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (cmd_valid) begin
                        cmd_q <= cmd_in;
                        unique case (cmd_in.kind)
                            K_CALL_REL: state <= S_PUSH;
                            K_CALL_IND: state <= cmd_in.opnd_mem ? S_FETCH : S_PUSH;
                            default:    state <= S_POP;
                        endcase
                    end
                end
                S_FETCH: begin
                    if (mem_ready) begin
                        cmd_q.target <= mem_rdata;
                        state        <= S_PUSH;
                    end
                end
                S_PUSH: begin
                    if (mem_ready) begin
                        rip_q <= cmd_q.target;
                        rsp_q <= rsp_after_push;
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end
                end
                S_POP: begin
                    if (mem_ready) begin
                        rip_q <= mem_rdata;
                        rsp_q <= rsp_after_pop;
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_rd    = (state == S_FETCH) || (state == S_POP);
        mem_wr    = (state == S_PUSH);
        busy      = (state != S_IDLE);
        mem_wdata = mem_wr ? cmd_q.next_ip : '0;
        unique case (state)
            S_FETCH: mem_addr = cmd_q.opnd_addr;
            S_PUSH:  mem_addr = push_addr;
            S_POP:   mem_addr = pop_addr;
            default: mem_addr = '0;
        endcase
    end
endmodule

// File: rtl/nearxfer_seq.sv
module nearxfer_seq
    import nearxfer_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_kind,
    input  logic [VA_W-1:0]    cmd_next_ip,
    input  logic [VA_W-1:0]    cmd_rsp,
    input  logic [DISP_W-1:0]  cmd_disp,
    input  logic [IMM_W-1:0]   cmd_imm,
    input  logic               cmd_opnd_mem,
    input  logic [VA_W-1:0]    cmd_opnd_reg,
    input  logic [VA_W-1:0]    cmd_opnd_addr,
    input  logic [VA_W-1:0]    ss_base,
    output logic               busy,
    output logic [VA_W-1:0]    mem_addr,
    output logic [VA_W-1:0]    mem_wdata,
    output logic               mem_rd,
    output logic               mem_wr,
    input  logic [VA_W-1:0]    mem_rdata,
    input  logic               mem_ready,
    output logic [VA_W-1:0]    rip_out,
    output logic [VA_W-1:0]    rsp_out,
    output logic               done
);
    xfer_kind_e      kind_in;
    logic [VA_W-1:0] early_target;
    xfer_cmd_t       cmd_in;
    xfer_cmd_t       cmd_q;
    logic [VA_W-1:0] push_addr, pop_addr, rsp_after_push, rsp_after_pop;

    assign kind_in = xfer_kind_e'(cmd_kind);

    nearxfer_target_sel u_tsel (
        .kind     (kind_in),
        .next_ip  (cmd_next_ip),
        .disp     (cmd_disp),
        .opnd_reg (cmd_opnd_reg),
        .target   (early_target)
    );

    always_comb begin
        cmd_in.kind      = kind_in;
        cmd_in.opnd_mem  = cmd_opnd_mem;
        cmd_in.next_ip   = cmd_next_ip;
        cmd_in.rsp       = cmd_rsp;
        cmd_in.target    = early_target;
        cmd_in.opnd_addr = cmd_opnd_addr;
        cmd_in.imm       = cmd_imm;
    end

    nearxfer_stack_agu #(
        .AW   (VA_W),
        .IW   (IMM_W),
        .SLOT (SLOT_BYTES)
    ) u_agu (
        .ss_base        (ss_base),
        .rsp            (cmd_q.rsp),
        .imm            (cmd_q.imm),
        .use_imm        (cmd_q.kind == K_RET_IMM),
        .push_addr      (push_addr),
        .pop_addr       (pop_addr),
        .rsp_after_push (rsp_after_push),
        .rsp_after_pop  (rsp_after_pop)
    );

    nearxfer_ctrl u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .cmd_valid      (cmd_valid),
        .cmd_in         (cmd_in),
        .push_addr      (push_addr),
        .pop_addr       (pop_addr),
        .rsp_after_push (rsp_after_push),
        .rsp_after_pop  (rsp_after_pop),
        .mem_rdata      (mem_rdata),
        .mem_ready      (mem_ready),
        .cmd_q          (cmd_q),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .mem_rd         (mem_rd),
        .mem_wr         (mem_wr),
        .rip_q          (rip_out),
        .rsp_q          (rsp_out),
        .done           (done),
        .busy           (busy)
    );
endmodule

// File: rtl/nearxfer_seq_chk.sv
module nearxfer_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic [63:0] mem_addr,
    input logic [63:0] mem_wdata,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic        mem_ready,
    input logic [63:0] rip_out,
    input logic [63:0] rsp_out,
    input logic        done
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr)); // R8

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr))); // R8

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata))); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(rip_out) && $stable(rsp_out))); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_rd && !mem_wr)); // R10

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R10

    AST_PUSH_ENDS: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && mem_ready) |=> done); // R3

    AST_FETCH_THEN_PUSH: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && mem_ready && !done) |=> (mem_wr || done)); // R5
endmodule

bind nearxfer_seq nearxfer_seq_chk u_chk (.*);

// File: tb/nearxfer_seq_tb.sv
`timescale 1ns/1ps
module nearxfer_seq_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [1:0]  cmd_kind;
    logic [63:0] cmd_next_ip, cmd_rsp, cmd_opnd_reg, cmd_opnd_addr, ss_base;
    logic [31:0] cmd_disp;
    logic [15:0] cmd_imm;
    logic        cmd_opnd_mem;
    logic        busy, mem_rd, mem_wr, done;
    logic [63:0] mem_addr, mem_wdata, mem_rdata, rip_out, rsp_out;
    logic        mem_ready;

    always #4 clk = ~clk;

    nearxfer_seq u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_next_ip(cmd_next_ip), .cmd_rsp(cmd_rsp), .cmd_disp(cmd_disp),
        .cmd_imm(cmd_imm), .cmd_opnd_mem(cmd_opnd_mem), .cmd_opnd_reg(cmd_opnd_reg),
        .cmd_opnd_addr(cmd_opnd_addr), .ss_base(ss_base), .busy(busy),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .rip_out(rip_out),
        .rsp_out(rsp_out), .done(done)
    );

    typedef struct {
        bit          wr;
        logic [63:0] addr;
        logic [63:0] data;
    } acc_t;

    int          checks = 0;
    int          errors = 0;
    acc_t        expq[$];
    logic [63:0] mem [logic [63:0]];
    int          lat = 0;
    int          wcnt = 0;
    bit          seen = 0;
    logic [63:0] model_rip = '0, model_rsp = '0, pend_rip = '0, pend_rsp = '0;
    bit          pend = 0;
    string       cur_tag = "R1";

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] memval(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    // memory responder with per-command latency; checks access order and addresses
    always @(negedge clk) begin
        if (rst) begin
            mem_ready = 1'b0;
            mem_rdata = '0;
            wcnt = 0;
            seen = 0;
        end else begin
            if (mem_ready) begin
                mem_ready = 1'b0;
                wcnt = 0;
            end
            if (mem_rd || mem_wr) begin
                if (!seen) begin
                    seen = 1;
                    if (expq.size() == 0) begin
                        chk(1'b0, "R10", "unexpected access", mem_addr, 64'd0);
                    end else begin
                        acc_t e;
                        e = expq.pop_front();
                        chk(e.wr == mem_wr, cur_tag, "access direction", {63'd0, mem_wr}, {63'd0, e.wr});
                        chk(mem_addr == e.addr, cur_tag, "access address", mem_addr, e.addr);
                        if (e.wr) chk(mem_wdata == e.data, "R3", "pushed value", mem_wdata, e.data);
                    end
                end
                if (wcnt >= lat) begin
                    if (mem_wr) mem[mem_addr] = mem_wdata;
                    else        mem_rdata = memval(mem_addr);
                    mem_ready = 1'b1;
                    seen = 0;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    // reference state compared on every cycle
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                if (!pend) chk(1'b0, "R9", "done without command", 64'd1, 64'd0);
                model_rip = pend_rip;
                model_rsp = pend_rsp;
                pend = 0;
            end
            chk(rip_out == model_rip, cur_tag, "rip_out", rip_out, model_rip);
            chk(rsp_out == model_rsp, cur_tag, "rsp_out", rsp_out, model_rsp);
        end
    end

    task automatic issue(input logic [1:0] k, input logic [63:0] nip, input logic [63:0] rsp,
                         input logic [63:0] base, input logic [31:0] disp, input logic [15:0] imm,
                         input bit om, input logic [63:0] oreg, input logic [63:0] oaddr,
                         input int l);
        logic [63:0] tgt;
        int n;
        lat = l;
        ss_base = base;
        if (k == 2'd0 || k == 2'd1) begin
            if (k == 2'd0) begin
                tgt = nip + {{32{disp[31]}}, disp};
                cur_tag = "R2";
            end else if (om) begin
                tgt = memval(oaddr);
                expq.push_back('{wr: 1'b0, addr: oaddr, data: 64'd0});
                cur_tag = "R5";
            end else begin
                tgt = oreg;
                cur_tag = "R4";
            end
            expq.push_back('{wr: 1'b1, addr: base + rsp - 64'd8, data: nip});
            pend_rip = tgt;
            pend_rsp = rsp - 64'd8;
        end else begin
            expq.push_back('{wr: 1'b0, addr: base + rsp, data: 64'd0});
            pend_rip = memval(base + rsp);
            pend_rsp = rsp + 64'd8 + ((k == 2'd3) ? {48'd0, imm} : 64'd0);
            cur_tag = (k == 2'd3) ? "R7" : "R6";
        end
        cmd_kind = k; cmd_next_ip = nip; cmd_rsp = rsp; cmd_disp = disp; cmd_imm = imm;
        cmd_opnd_mem = om; cmd_opnd_reg = oreg; cmd_opnd_addr = oaddr;
        cmd_valid = 1'b1;
        pend = 1;
        @(negedge clk);
        chk(busy == 1'b1, "R10", "busy after accept", {63'd0, busy}, 64'd1);
        n = 0;
        while (!done && n < 1000) begin
            // junk command while busy must be ignored (R10)
            cmd_valid = 1'b1;
            cmd_kind = 2'($urandom);
            cmd_rsp = {$urandom, $urandom};
            cmd_next_ip = {$urandom, $urandom};
            cmd_opnd_mem = 1'b1;
            @(negedge clk);
            n++;
        end
        cmd_valid = 1'b0;
        chk(done == 1'b1, cur_tag, "done reached", {63'd0, done}, 64'd1);
        chk(expq.size() == 0, cur_tag, "accesses outstanding", 64'(expq.size()), 64'd0);
        expq.delete();
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1;
        cmd_valid = 1'b0; cmd_kind = '0; cmd_next_ip = '0; cmd_rsp = '0; cmd_disp = '0;
        cmd_imm = '0; cmd_opnd_mem = 1'b0; cmd_opnd_reg = '0; cmd_opnd_addr = '0; ss_base = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(rip_out == 64'd0, "R1", "reset rip", rip_out, 64'd0);
        chk(rsp_out == 64'd0, "R1", "reset rsp", rsp_out, 64'd0);
        chk({busy, done, mem_rd, mem_wr} == 4'd0, "R1", "reset flags",
            {60'd0, busy, done, mem_rd, mem_wr}, 64'd0);
        @(negedge clk);

        // R2 forward and most negative displacement
        issue(2'd0, 64'h1000, 64'h8000, 64'h10000, 32'h100, 16'd0, 1'b0, 64'd0, 64'd0, 0);
        issue(2'd0, 64'h4000_0000_0000_0010, 64'h7ff0, 64'h0, 32'h8000_0000, 16'd0, 1'b0, 64'd0, 64'd0, 2);
        // R4 register target
        issue(2'd1, 64'h2222, 64'h9000, 64'h100, 32'd0, 16'd0, 1'b0, 64'hdead_beef_0000_1234, 64'd0, 1);
        // R5 memory target
        mem[64'h5_0000] = 64'hfeed_face_cafe_0001;
        issue(2'd1, 64'h3333, 64'hA000, 64'h200, 32'd0, 16'd0, 1'b1, 64'd1, 64'h5_0000, 1);
        // R6 plain return
        mem[64'h300 + 64'hB000] = 64'h0123_4567_89ab_cdef;
        issue(2'd2, 64'd0, 64'hB000, 64'h300, 32'd0, 16'd0, 1'b0, 64'd0, 64'd0, 0);
        // R7 largest release count
        mem[64'h400 + 64'hC000] = 64'h0000_7777_0000_8888;
        issue(2'd3, 64'd0, 64'hC000, 64'h400, 32'd0, 16'hFFFF, 1'b0, 64'd0, 64'd0, 3);
        // R3 push wraps below zero, R6 pop wraps back to zero
        issue(2'd0, 64'h55, 64'd0, 64'd0, 32'hFFFF_FFF0, 16'd0, 1'b0, 64'd0, 64'd0, 0);
        issue(2'd2, 64'd0, 64'hFFFF_FFFF_FFFF_FFF8, 64'd0, 32'd0, 16'd0, 1'b0, 64'd0, 64'd0, 1);

        for (int i = 0; i < 24; i++) begin
            logic [1:0]  k;
            logic [63:0] rsp, base, oa;
            k = 2'($urandom);
            rsp = {$urandom, $urandom};
            base = {$urandom, $urandom};
            oa = {$urandom, $urandom};
            if (k >= 2'd2) mem[base + rsp] = {$urandom, $urandom};
            if (k == 2'd1) mem[oa] = {$urandom, $urandom};
            issue(k, {$urandom, $urandom}, rsp, base, $urandom, 16'($urandom),
                  1'($urandom), {$urandom, $urandom}, oa, int'($urandom % 4));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule